// File: doc/BRIEF.md
# Mode-Switchable ROM/RAM Bank Mapper

This block sits between an 8-bit CPU bus with a 16-bit address and a cartridge's ROM and RAM. A CPU store into the ROM address range does not change ROM contents. The block decodes it as a control write instead: it can turn RAM access on or off, load a 5-bit ROM bank field, load a 2-bit secondary bank field, or select a mapping mode. For CPU loads, the block turns the 16-bit address into a physical ROM byte address, which goes to external ROM storage. It also serves bytes from a banked RAM array that is held inside the block.

The secondary field always extends the bank number used for the switchable ROM window at 0x4000–0x7FFF. The mode bit controls two further uses of that field. In mode 1 it also relocates the normally fixed window at 0x0000–0x3FFF, and it selects the RAM bank. In mode 0 the low window is an identity map and RAM bank 0 is always used. Every bank number is masked to the banks actually fitted, so a field larger than the device wraps around instead of pointing outside it.

The ROM bank count, the RAM bank count (0 means no RAM fitted) and the RAM bank size are parameters.

Top module: `bank_mapper`

## Requirements
- R1: After reset, the ROM bank field is 1, and the secondary field, the mode bit and the RAM enable are all 0.
- R2: A write with address bits [15:13] = 001 loads data[4:0] into the ROM bank field. A value of 0 is stored as 1, and data bits [7:5] have no effect.
- R3: A write with address bits [15:13] = 000 enables RAM when data[3:0] = 0xA and disables it for any other value. Data bits [7:4] are ignored.
- R4: A write with address bits [15:13] = 010 loads data[1:0] into the 2-bit secondary field.
- R5: A write with address bits [15:13] = 011 sets the mode bit to data[0].
- R6: A read with address bits [15:14] = 01 gives rom_addr = bank_hi × 0x4000 + addr[13:0]. Here bank_hi = ((secondary << 5) | rom bank field) & (ROM_BANKS − 1).
- R7: A read with address bits [15:14] = 00 gives rom_addr = addr in mode 0. In mode 1 it gives ((secondary << 5) & (ROM_BANKS − 1)) × 0x4000 + addr.
- R8: The RAM window 0xA000–0xBFFF uses the RAM bank secondary & (RAM_BANKS − 1) in mode 1 and bank 0 in mode 0. The byte index within the bank is addr[RAM_BANK_AW−1:0], so higher offset bits alias.
- R9: rd_data is 0xFF whenever the address is outside the RAM window, RAM is disabled, or RAM_BANKS = 0. Otherwise it is the stored byte.
- R10: A write to the RAM window while RAM is disabled, or with RAM_BANKS = 0, changes no stored byte.
- R11: rom_hit is 1 exactly for addresses below 0x8000, and ram_hit is 1 exactly for 0xA000–0xBFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | CPU write strobe, one cycle per write |
| rom_hit | output | 1 | Address lies in the ROM range |
| rom_addr | output | 14+log2(ROM_BANKS) | Physical ROM byte address |
| ram_hit | output | 1 | Address lies in the RAM window |
| rd_data | output | 8 | Read byte from the RAM window, or 0xFF |

## Verification
The main instance is built with ROM_BANKS = 64, RAM_BANKS = 4 and RAM_BANK_AW = 4. With 64 banks, the low secondary bit survives the mask and the high one is cut off. Every secondary value, every ROM bank field value and both modes can then be swept, which exercises both the wrap of the masking and the relocation of the low window. With 16-byte RAM banks, every byte of every bank can be written and read back, including aliased offsets. A second instance with RAM_BANKS = 0 runs on the same bus to show that the no-RAM variant reads 0xFF and ignores writes.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

    localparam int unsigned WIN_SHIFT = 14;   // bytes per ROM bank = 2**14
    localparam int unsigned LOW_W     = 5;
    localparam int unsigned SEC_W     = 2;
    localparam int unsigned FULL_W    = LOW_W + SEC_W;

    // Address segment selected by addr[15:13]
    typedef enum logic [2:0] {
        SEG_RAMEN = 3'b000,
        SEG_ROMLO = 3'b001,
        SEG_SEC   = 3'b010,
        SEG_MODE  = 3'b011,
        SEG_GAP   = 3'b100,
        SEG_RAM   = 3'b101,
        SEG_HIA   = 3'b110,
        SEG_HIB   = 3'b111
    } seg_e;

    typedef struct packed {
        logic             ram_en;
        logic             mode;
        logic [SEC_W-1:0] sec;
        logic [LOW_W-1:0] low;
    } map_regs_t;

    localparam map_regs_t REGS_AT_RESET = '{ram_en: 1'b0, mode: 1'b0,
                                            sec: '0, low: LOW_W'(1)};

    function automatic logic [LOW_W-1:0] nonzero_low(input logic [LOW_W-1:0] d);
        return (d == '0) ? LOW_W'(1) : d;
    endfunction

    function automatic seg_e seg_of(input logic [15:0] a);
        return seg_e'(a[15:13]);
    endfunction

endpackage

// File: rtl/bm_regs.sv
module bm_regs
    import bankmap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output map_regs_t   regs
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= REGS_AT_RESET;
        end else if (wr) begin
            case (seg_of(addr))
                SEG_RAMEN: regs.ram_en <= (wdata[3:0] == 4'hA);
                SEG_ROMLO: regs.low    <= nonzero_low(wdata[LOW_W-1:0]);
                SEG_SEC:   regs.sec    <= wdata[SEC_W-1:0];
                SEG_MODE:  regs.mode   <= wdata[0];
                default: ;
            endcase
        end
    end

    logic unused_regs_bits;
    assign unused_regs_bits = ^{addr[12:0], wdata[7:5]};

    a_r1_reset_values: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (regs.low == LOW_W'(1) && regs.sec == '0 && !regs.mode && !regs.ram_en));

    a_r2_zero_becomes_one: assert property (@(posedge clk) disable iff (rst)
        (wr && addr[15:13] == 3'b001 && wdata[4:0] == 5'd0) |=> (regs.low == LOW_W'(1)));

    a_r3_enable_key: assert property (@(posedge clk) disable iff (rst)
        (wr && addr[15:13] == 3'b000) |=> (regs.ram_en == ($past(wdata[3:0]) == 4'hA)));

    a_r4_secondary_load: assert property (@(posedge clk) disable iff (rst)
        (wr && addr[15:13] == 3'b010) |=> (regs.sec == $past(wdata[1:0])));

    a_r5_mode_load: assert property (@(posedge clk) disable iff (rst)
        (wr && addr[15:13] == 3'b011) |=> (regs.mode == $past(wdata[0])));

endmodule

// File: rtl/bm_rom_map.sv
module bm_rom_map
    import bankmap_pkg::*;
#(
    parameter int unsigned ROM_BANKS = 128,
    localparam int unsigned ROM_BW   = $clog2(ROM_BANKS),
    localparam int unsigned ROM_AW   = WIN_SHIFT + ROM_BW
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       addr,
    input  map_regs_t         regs,
    output logic              rom_hit,
    output logic [ROM_AW-1:0] rom_addr
);

    localparam logic [FULL_W-1:0] BANK_MASK = FULL_W'(ROM_BANKS - 1);

    logic [FULL_W-1:0] bank_hi;
    logic [FULL_W-1:0] bank_lo;
    logic [FULL_W-1:0] bank_sel;

    always_comb begin
        bank_hi  = {regs.sec, regs.low} & BANK_MASK;
        bank_lo  = {regs.sec, LOW_W'(0)} & BANK_MASK;
        if (addr[14])
            bank_sel = bank_hi;
        else if (regs.mode)
            bank_sel = bank_lo;
        else
            bank_sel = '0;
        rom_hit  = !addr[15];
        rom_addr = ROM_AW'({bank_sel, addr[WIN_SHIFT-1:0]});
    end

    logic unused_rom_bits;
    assign unused_rom_bits = regs.ram_en;

    a_r7_identity_in_mode0: assert property (@(posedge clk) disable iff (rst)
        (addr[15:14] == 2'b00 && !regs.mode) |-> (rom_addr == ROM_AW'(addr)));

    a_r6_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (addr[15:14] == 2'b01) |-> (rom_addr[WIN_SHIFT-1:0] == addr[WIN_SHIFT-1:0]));

    a_r11_rom_range: assert property (@(posedge clk) disable iff (rst)
        rom_hit == (addr < 16'h8000));

endmodule

// File: rtl/bm_ram.sv
module bm_ram
    import bankmap_pkg::*;
#(
    parameter int unsigned RAM_BANKS   = 4,
    parameter int unsigned RAM_BANK_AW = 8
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    input  map_regs_t   regs,
    output logic        ram_hit,
    output logic [7:0]  rd_data
);

    assign ram_hit = (seg_of(addr) == SEG_RAM);

    generate
        if (RAM_BANKS == 0) begin : g_absent
            assign rd_data = 8'hFF;
            logic unused_absent_bits;
            assign unused_absent_bits = ^{wr, wdata, regs, addr[12:0]};
        end else begin : g_present
            localparam int unsigned DEPTH = RAM_BANKS << RAM_BANK_AW;
            localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
            localparam logic [SEC_W-1:0] RB_MASK = SEC_W'(RAM_BANKS - 1);

            logic [7:0]       mem [DEPTH];
            logic [SEC_W-1:0] bank;
            logic [IDX_W-1:0] idx;
            logic             open;

            always_comb begin
                bank    = regs.mode ? (regs.sec & RB_MASK) : '0;
                idx     = IDX_W'({bank, addr[RAM_BANK_AW-1:0]});
                open    = ram_hit && regs.ram_en;
                rd_data = open ? mem[idx] : 8'hFF;
            end

            always_ff @(posedge clk) begin
                if (wr && open)
                    mem[idx] <= wdata;
            end

            logic unused_present_bits;
            assign unused_present_bits = ^{regs.low, addr[12:0]};

            a_r10_write_needs_enable: assert property (@(posedge clk) disable iff (rst)
                (wr && ram_hit && regs.ram_en) |=> (rd_data == $past(wdata) || addr != $past(addr) || !regs.ram_en || regs.sec != $past(regs.sec) || regs.mode != $past(regs.mode)));
        end
    endgenerate

    a_r9_closed_reads_ff: assert property (@(posedge clk) disable iff (rst)
        (!ram_hit || !regs.ram_en) |-> (rd_data == 8'hFF));

    a_r11_ram_range: assert property (@(posedge clk) disable iff (rst)
        ram_hit == (addr >= 16'hA000 && addr <= 16'hBFFF));

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bankmap_pkg::*;
#(
    parameter int unsigned ROM_BANKS   = 128,
    parameter int unsigned RAM_BANKS   = 4,
    parameter int unsigned RAM_BANK_AW = 8,
    localparam int unsigned ROM_AW     = WIN_SHIFT + $clog2(ROM_BANKS)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    output logic              rom_hit,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              ram_hit,
    output logic [7:0]        rd_data
);

    map_regs_t regs;

    bm_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .regs  (regs)
    );

    bm_rom_map #(.ROM_BANKS(ROM_BANKS)) u_rom (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .regs     (regs),
        .rom_hit  (rom_hit),
        .rom_addr (rom_addr)
    );

    bm_ram #(.RAM_BANKS(RAM_BANKS), .RAM_BANK_AW(RAM_BANK_AW)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .regs    (regs),
        .ram_hit (ram_hit),
        .rd_data (rd_data)
    );

endmodule

// File: tb/test_bank_mapper.sv
module test_bank_mapper;

    localparam int CLK_PERIOD = 10;
    localparam int NBANKS     = 64;
    localparam int RBANKS     = 4;
    localparam int RAW        = 4;
    localparam int RAW_W      = 14 + $clog2(NBANKS);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [15:0]       bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic              bus_wr = 1'b0;
    logic              rom_hit, ram_hit, nr_rom_hit, nr_ram_hit;
    logic [RAW_W-1:0]  rom_addr, nr_rom_addr;
    logic [7:0]        rd_data, nr_rd_data;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_mapper #(.ROM_BANKS(NBANKS), .RAM_BANKS(RBANKS), .RAM_BANK_AW(RAW)) i_bank_mapper (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .rom_hit(rom_hit), .rom_addr(rom_addr), .ram_hit(ram_hit), .rd_data(rd_data));

    bank_mapper #(.ROM_BANKS(NBANKS), .RAM_BANKS(0), .RAM_BANK_AW(RAW)) i_bank_mapper_noram (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .rom_hit(nr_rom_hit), .rom_addr(nr_rom_addr), .ram_hit(nr_ram_hit), .rd_data(nr_rd_data));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_look(input logic [15:0] a);
        @(negedge clk);
        bus_addr = a;
        bus_wr   = 1'b0;
        #1;
    endtask

    function automatic logic [7:0] pat(input int b, input int o);
        return 8'((b * 37 + o * 11) ^ 8'h5A);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state seen at the ports
        bus_look(16'h4000);
        check("R1 upper window bank 1", 32'(rom_addr), 32'h4000);
        bus_look(16'h0123);
        check("R1 mode 0 low window", 32'(rom_addr), 32'h0123);
        bus_look(16'hA000);
        check("R1 RAM disabled", 32'(rd_data), 32'hFF);

        // R11: range flags
        bus_look(16'h7FFF);
        check("R11 rom_hit top", 32'({rom_hit, ram_hit}), 32'b10);
        bus_look(16'h8000);
        check("R11 rom_hit off", 32'({rom_hit, ram_hit}), 32'b00);
        bus_look(16'hBFFF);
        check("R11 ram_hit", 32'({rom_hit, ram_hit}), 32'b01);
        bus_look(16'hC000);
        check("R11 past window", 32'({rom_hit, ram_hit}), 32'b00);
        check("R9 outside window FF", 32'(rd_data), 32'hFF);

        // R2, R4, R5, R6, R7: full sweep of secondary, low field and mode
        for (int s = 0; s < 4; s++) begin
            for (int l = 0; l < 32; l++) begin
                for (int m = 0; m < 2; m++) begin
                    int le, hb, zb, off;
                    bus_write(16'h4000 | 16'(l * 5), 8'((l << 2) | s));
                    bus_write(16'h2000 | 16'(s * 3), 8'(((s + l) << 5) | l));
                    bus_write(16'h6000, 8'(8'h80 | (l << 1) | m));
                    le  = (l == 0) ? 1 : l;
                    hb  = ((s << 5) | le) & (NBANKS - 1);
                    zb  = (s << 5) & (NBANKS - 1);
                    off = (l * 97 + s * 13 + m * 4001) & 16'h3FFF;
                    bus_look(16'(off));
                    check("R7 low window", 32'(rom_addr), 32'(m ? zb * 16384 + off : off));
                    bus_look(16'(16'h4000 + off));
                    check("R6 R2 R4 upper window", 32'(rom_addr), 32'(hb * 16384 + off));
                end
            end
        end

        // R3: key nibble 0xA with upper bits ignored
        bus_write(16'h0000, 8'hA0);
        bus_look(16'hA000);
        check("R3 0xA0 keeps disabled", 32'(rd_data), 32'hFF);
        bus_write(16'h1FFF, 8'h5A);
        bus_write(16'h6000, 8'h01);

        // R8: fill every bank in mode 1, read back with aliasing offsets
        for (int b = 0; b < RBANKS; b++) begin
            bus_write(16'h5000, 8'(b));
            for (int o = 0; o < 16; o++)
                bus_write(16'(16'hA000 + o), pat(b, o));
        end
        for (int b = 0; b < RBANKS; b++) begin
            bus_write(16'h4000, 8'(8'hFC | b));
            for (int o = 0; o < 16; o++) begin
                bus_look(16'(16'hA000 + o + 16'h0110 * b));
                check("R8 R9 banked read", 32'(rd_data), 32'(pat(b, o)));
                check("R9 R10 no-RAM variant FF", 32'(nr_rd_data), 32'hFF);
            end
        end

        // R8: mode 0 forces bank 0 even with secondary = 3
        bus_write(16'h4000, 8'h03);
        bus_write(16'h7000, 8'h00);
        for (int o = 0; o < 16; o += 5) begin
            bus_look(16'(16'hB000 + o));
            check("R8 mode 0 uses bank 0", 32'(rd_data), 32'(pat(0, o)));
        end

        // R10: writes while disabled are dropped
        bus_write(16'h0000, 8'h0B);
        bus_look(16'hA003);
        check("R3 non-key disables", 32'(rd_data), 32'hFF);
        for (int o = 0; o < 16; o++)
            bus_write(16'(16'hA000 + o), 8'h00);
        bus_write(16'h0400, 8'h3A);
        for (int o = 0; o < 16; o++) begin
            bus_look(16'(16'hA000 + o));
            check("R10 data kept across disabled writes", 32'(rd_data), 32'(pat(0, o)));
        end

        // R2: zero with high bits set becomes 1
        bus_write(16'h4000, 8'h00);
        bus_write(16'h2000, 8'hE0);
        bus_look(16'h4005);
        check("R2 zero stored as one", 32'(rom_addr), 32'h4005);

        // R1: reset again restores defaults
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        bus_look(16'h7000);
        check("R1 bank after second reset", 32'(rom_addr), 32'h7000);
        bus_look(16'hA000);
        check("R1 RAM off after second reset", 32'(rd_data), 32'hFF);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule